// File: doc/BRIEF.md
# Register-Staged Memory Access Unit

This block is a word-addressed random-access store that is never reached directly. Every access passes through an address register and a data register under the control of a short, fixed sequencer. A requester presents a command with a valid/ready handshake. The command holds a read-or-write select, a cell address and, for writes, a data word. The unit then walks through the steps of the access. The read-data output always shows the data register.

A read latches the address, decodes it into a one-hot row select, and copies the selected cell into the data register. At that point a one-cycle valid pulse is raised. A write latches the address, moves the supplied word into the data register, decodes, and then writes the data register into the selected cell. Every access occupies the unit for the same number of cycles. The address and the data do not change that count. Commands offered while the unit is busy are not taken.

Top module: `mem_access_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the unit leaves that edge with cmd_ready = 1, rd_valid = 0 and rd_data = 0.
- R2: Every address from 0 to 2^ADDR_W − 1 (0 to 255 by default) selects its own cell. A write to one address leaves every other cell unchanged.
- R3: A read (cmd_write = 0) copies the whole addressed cell to rd_data and leaves the cell unchanged, so repeated reads return the same word.
- R4: A write (cmd_write = 1) replaces all DATA_W bits of the addressed cell with cmd_wdata, and a later read returns exactly that word.
- R5: A command is taken at a clock edge where cmd_valid and cmd_ready are both 1. After that edge cmd_ready stays 0 for exactly three cycles and then returns to 1.
- R6: For a read, rd_valid is 1 for exactly one cycle, which is the cycle in which cmd_ready returns to 1, and rd_data then holds the cell. A write never raises rd_valid.
- R7: For a write, the data register takes cmd_wdata at the first edge after acceptance, so rd_data shows the write word two cycles before the access completes.
- R8: The number of busy cycles is the same for every address and data value, and the same for reads and writes.
- R9: cmd_valid, cmd_write, cmd_addr and cmd_wdata are ignored while cmd_ready is 0. Such a command changes no cell and does not change rd_data.
- R10: rd_data changes only when a write loads the data register or when a read completes. Otherwise it holds its value between accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, a command is taken this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Cell address |
| cmd_wdata | input | DATA_W | Word to write |
| rd_valid | output | 1 | One-cycle pulse: read data is in the data register |
| rd_data | output | DATA_W | Data register contents |

## Verification
Writes of all-ones, all-zeros, alternating-bit words and a single set bit at each end go to the lowest, highest and neighbouring addresses. These tell a dropped or stuck data bit apart from an address decode that aliases neighbouring cells. Reads of the same cell repeated back to back separate a non-destructive read from one that disturbs the cell. A scattered write-then-read sweep in reverse order catches decode faults that only certain address bits expose. Noise commands driven during a busy window, aimed at a cell with known contents, separate a unit that correctly ignores them from one that takes them mid-sequence. A behavioural model compares ready, the valid pulse and the data register every cycle, which pins each staging step to its cycle.

// File: rtl/mau_pkg.sv
// Package for the register-staged memory access unit.
// Holds the sequencer state type shared by the sequencer and its checks.
package mau_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a command
        ST_DATA = 2'd1,   // data register staging step
        ST_DEC  = 2'd2,   // address decode step
        ST_XFER = 2'd3    // cell <-> data register transfer
    } mau_state_e;
endpackage

// File: rtl/mau_seq.sv
// Sequencer: accepts one command at a time and steps it through
// data staging, decode and transfer. Assumes the register and array
// slices act only on the strobes issued here.
module mau_seq
    import mau_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_write,
    output logic cmd_ready,
    output logic acc,
    output logic ld_data,
    output logic dec,
    output logic xfer,
    output logic op_wr,
    output logic rd_valid
);
    mau_state_e state_q;

    // Strobes decoded from the current step.
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        acc       = cmd_valid && cmd_ready;
        ld_data   = (state_q == ST_DATA);
        dec       = (state_q == ST_DEC);
        xfer      = (state_q == ST_XFER);
    end

    // Step advance, latched operation and read-complete pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            op_wr    <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= xfer && !op_wr;
            if (acc) op_wr <= cmd_write;
            case (state_q)
                ST_IDLE: if (acc) state_q <= ST_DATA;
                ST_DATA: state_q <= ST_DEC;
                ST_DEC:  state_q <= ST_XFER;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: reset leaves the unit idle with no valid pulse.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (cmd_ready && !rd_valid));
    // R5: busy right after acceptance and still busy two cycles later.
    a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !cmd_ready);
    a_r5_busy_third_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> ##3 !cmd_ready);
    // R6: valid pulse lasts one cycle and coincides with ready.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    a_r6_pulse_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> cmd_ready);
    // R6: a write never produces a valid pulse.
    a_r6_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_write) |-> ##4 !rd_valid);
endmodule

// File: rtl/mau_regs.sv
// Address register, write holding register, data register and the
// registered one-hot decode of the address. Assumes strobes from
// mau_seq are mutually exclusive.
module mau_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              ld_data,
    input  logic              dec,
    input  logic              xfer,
    input  logic              op_wr,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] cell_rdata,
    output logic [DATA_W-1:0] mdr,
    output logic [DEPTH-1:0]  sel
);
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] hold;
    logic [DEPTH-1:0]  hit;

    // One comparator per cell forms the decoded address.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_dec
        assign hit[gi] = (mar == ADDR_W'(gi));
    end

    // Register staging: address, held word, data register, row select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar  <= '0;
            hold <= '0;
            mdr  <= '0;
            sel  <= '0;
        end else begin
            if (acc) begin
                mar  <= cmd_addr;
                hold <= cmd_wdata;
            end
            if (ld_data && op_wr) mdr <= hold;
            if (xfer && !op_wr)   mdr <= cell_rdata;
            if (dec)              sel <= hit;
            else if (xfer)        sel <= '0;
        end
    end

    // R2: exactly one row is selected when the transfer happens.
    a_r2_one_row: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> ($countones(sel) == 1));
    // R2: no row is selected outside the transfer window.
    a_r2_idle_no_row: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> ($countones(sel) == 0));
endmodule

// File: rtl/mau_array.sv
// Cell storage: one DATA_W word per address. Written only in the
// transfer step of a write, read through the one-hot row select.
// Assumes sel is one-hot or zero.
module mau_array #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              we,
    input  logic [DEPTH-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    // Whole-cell write into the selected row.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (we && sel[i]) cells[i] <= wdata;
        end
    end

    // AND-OR read of the selected row.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel[i]) rdata = rdata | cells[i];
        end
    end
endmodule

// File: rtl/mem_access_unit.sv
// Top of the register-staged memory access unit. Ties the sequencer,
// the staging registers and the cell array together. rd_data is the
// data register. Assumes a single requester on the command port.
module mem_access_unit #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic              acc, ld_data, dec, xfer, op_wr;
    logic [DEPTH-1:0]  sel;
    logic [DATA_W-1:0] cell_rdata;
    logic [DATA_W-1:0] mdr;

    mau_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_ready (cmd_ready),
        .acc       (acc),
        .ld_data   (ld_data),
        .dec       (dec),
        .xfer      (xfer),
        .op_wr     (op_wr),
        .rd_valid  (rd_valid)
    );

    mau_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .ld_data    (ld_data),
        .dec        (dec),
        .xfer       (xfer),
        .op_wr      (op_wr),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .cell_rdata (cell_rdata),
        .mdr        (mdr),
        .sel        (sel)
    );

    mau_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .we    (xfer && op_wr),
        .sel   (sel),
        .wdata (mdr),
        .rdata (cell_rdata)
    );

    assign rd_data = mdr;

    // R7: a write word appears on rd_data two edges after acceptance.
    a_r7_write_staged: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_write) |-> ##2 (rd_data == $past(cmd_wdata, 2)));
    // R10: rd_data holds while the unit is idle and no command is taken.
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !cmd_valid && !rd_valid) |=> $stable(rd_data));
endmodule

// File: tb/sim_mem_access_unit.sv
`timescale 1ns/1ps
module sim_mem_access_unit;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          cmd_ready;
    logic          rd_valid;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit started = 1'b0;

    // Behavioural model state.
    int          m_busy = 0;
    bit          m_wr = 1'b0;
    int          m_a = 0;
    logic [DW-1:0] m_wd = '0;
    logic [DW-1:0] m_mdr = '0;
    bit          m_rv = 1'b0;
    logic [DW-1:0] mm [int];

    always #2 clk = ~clk;

    mem_access_unit #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model, stepped on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_mdr = '0; m_rv = 1'b0; started = 1'b1;
        end else begin
            m_rv = 1'b0;
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 2 && m_wr) m_mdr = m_wd;
                if (m_busy == 0) begin
                    if (m_wr) mm[m_a] = m_mdr;
                    else begin m_mdr = mm[m_a]; m_rv = 1'b1; end
                end
            end else if (cmd_valid) begin
                m_busy = 3; m_wr = cmd_write; m_a = int'(cmd_addr); m_wd = cmd_wdata;
            end
        end
    end

    // Every-cycle comparison (R1, R5, R6, R7, R10).
    always @(negedge clk) begin
        if (started) begin
            chk("R5 ready", 32'(cmd_ready), 32'(m_busy == 0));
            chk("R6 rd_valid", 32'(rd_valid), 32'(m_rv));
            chk("R7/R10 rd_data", 32'(rd_data), 32'(m_mdr));
        end
    end

    // Watchdog.
    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // One access; checks latency (R5, R8) and read completion (R3, R6).
    task automatic access(input bit wr, input int a, input logic [DW-1:0] d,
                          input bit noise, input logic [DW-1:0] exp);
        int lat;
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = AW'(a); cmd_wdata = d;
        @(negedge clk);
        lat = 0;
        if (noise) begin
            cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = AW'(a + 1); cmd_wdata = ~d;
        end else cmd_valid = 1'b0;
        while (!cmd_ready) begin
            lat++;
            if (lat == 2) cmd_valid = 1'b0;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk("R5/R8 busy cycles", 32'(lat), 32'd3);
        if (!wr) begin
            chk("R6 valid on completion", 32'(rd_valid), 32'd1);
            chk("R3 read word", 32'(rd_data), 32'(exp));
        end else begin
            chk("R6 write no valid", 32'(rd_valid), 32'd0);
            chk("R4 word staged", 32'(rd_data), 32'(d));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready", 32'(cmd_ready), 32'd1);
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        chk("R1 rd_data", 32'(rd_data), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R4: boundary addresses, distinctive words.
        access(1, 0,   16'hFFFF, 0, 0);
        access(1, 255, 16'h8001, 0, 0);
        access(1, 1,   16'h0000, 0, 0);
        access(1, 254, 16'hA5A5, 0, 0);
        access(0, 0,   0, 0, 16'hFFFF);   // R2
        access(0, 255, 0, 0, 16'h8001);   // R2
        access(0, 1,   0, 0, 16'h0000);   // R2
        access(0, 254, 0, 0, 16'hA5A5);   // R2
        // R3: repeated reads leave the cell intact.
        access(0, 0,   0, 0, 16'hFFFF);
        access(0, 0,   0, 0, 16'hFFFF);
        // R4: overwrite.
        access(1, 1,   16'h5A5A, 0, 0);
        access(0, 1,   0, 0, 16'h5A5A);
        // R10: idle hold.
        repeat (5) @(negedge clk);
        chk("R10 hold", 32'(rd_data), 32'h5A5A);
        // R8: scattered sweep.
        for (int i = 2; i < 18; i++) access(1, (i * 37) % 256, DW'(i * 4099), 0, 0);
        for (int i = 17; i >= 2; i--) access(0, (i * 37) % 256, 0, 0, DW'(i * 4099));
        // R9: noise while busy aimed at cell 255 (a+1 of 254).
        access(1, 254, 16'h1234, 1, 0);
        access(0, 255, 0, 0, 16'h8001);   // R9 cell untouched
        access(0, 254, 0, 1, 16'h1234);   // R9 during a read
        access(0, 255, 0, 0, 16'h8001);
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule